// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver with Clock Stretching

This block is the receive side of an I2C target device. It follows the bus through two-flop synchronizers and detects START and STOP conditions. It collects a 7-bit address plus a direction bit and, when both fit, acknowledges on the ninth clock. It then accepts data bytes into a single holding register. The SCL and SDA pads are open drain. The block never drives a line high: it only asserts a pull-low enable for each line.

The host side is a set of strobes and flags:
- A one-cycle read strobe consumes the holding register.
- Separate strobes clear the interrupt and overflow flags.
- A release strobe sets the clock-release bit.

When stretching is enabled, the block holds SCL low after an acknowledged byte if the holding register is still occupied at the end of the acknowledge clock. It keeps SCL low until the host sets the release bit. A byte that arrives while the register is still occupied is refused: it is not acknowledged and the overflow flag is set.

The controller has seven states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ACK`: drives the acknowledge.
- `ST_NACK`: lets a refused data byte pass.
- `ST_DATA`: shifts in a data byte.
- `ST_HOLD`: stretches SCL.
- `ST_SKIP`: ignores a transfer that is not addressed to this device.

Its transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ACK` on a matching write address with a free register. Otherwise it goes to `ST_SKIP`.
- `ST_DATA` goes to `ST_ACK` when the register is free, and to `ST_NACK` when it is occupied.
- `ST_ACK` goes to `ST_HOLD` or `ST_DATA` at the ninth falling edge.
- `ST_NACK` goes to `ST_DATA` at the ninth falling edge.
- `ST_HOLD` goes to `ST_DATA` on the release strobe.

Top module: `i2c_wr_slave`

## Requirements
- R1: After reset, both pull-low enables are 0, the full, overflow and interrupt flags are 0, and the clock-release bit `clk_rel` is 1.
- R2: A START followed by the 7 bits of `own_addr` (MSB first) and a direction bit of 0 is acknowledged: SDA is pulled low during the ninth clock. Any other address, or a direction bit of 1, is not acknowledged. The rest of that transfer then sets no flag, loads no byte and stretches nothing until the next START.
- R3: An accepted byte, shifted in MSB first, appears on `rd_data` and sets `buf_full` at the end of its eighth clock. `irq` is set at the falling edge of the ninth clock. For the address byte the value is `{address, direction}`.
- R4: A `rd_en` pulse clears `buf_full`. A `clr_irq` pulse clears `irq`. A `clr_ovf` pulse clears `ovf`.
- R5: With `stretch_en` = 1, suppose a byte is acknowledged and `buf_full` is still 1 at the ninth falling edge. The block then clears `clk_rel` to 0 and holds `scl_oe` at 1. `scl_oe` stays at 1 until a `rel_set` pulse, which releases SCL and sets `clk_rel` back to 1. Reading the buffer while SCL is held does not release it.
- R6: If the host pulses `rd_en` after the eighth clock and before the ninth falling edge, the byte is still acknowledged. No stretching happens and `clk_rel` stays 1.
- R7: With `stretch_en` = 0, SCL is never held low.
- R8: A data byte that completes while `buf_full` is 1 is not acknowledged (SDA left high) and sets `ovf`. `rd_data` keeps the earlier byte and SCL is not held.
- R9: `ovf` stays set across later reads and accepted bytes until `clr_ovf`.
- R10: A STOP ends the transfer, so bits clocked after it without a new START are ignored. A repeated START in any state begins a new address phase.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Device address to respond to |
| stretch_en | input | 1 | Enables clock stretching |
| rd_en | input | 1 | Read strobe for the holding register, clears `buf_full` |
| rd_data | output | 8 | Holding register contents |
| clr_irq | input | 1 | Clears `irq` |
| clr_ovf | input | 1 | Clears `ovf` |
| rel_set | input | 1 | Sets the clock-release bit and ends a stretch |
| buf_full | output | 1 | Holding register occupied |
| ovf | output | 1 | A byte arrived while the register was occupied |
| irq | output | 1 | Byte received interrupt |
| clk_rel | output | 1 | Clock-release bit |

## Verification
The checker watches several invariants on every cycle:
- SDA is driven only while SCL is low.
- A stretch begins only with stretching enabled and a full register, and it persists until the release strobe.
- While SCL is held, `clk_rel` reads 0 and no acknowledge is driven.
- Overflow rises only on a refused byte and stays set until cleared.

Only the directed scenarios can show the rest:
- The address decision.
- The byte values MSB first.
- The read-before-ninth-edge case that skips the stretch.
- Bits after a STOP being ignored.
- A repeated START recovering from an ignored or read transfer.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_NACK,
        ST_DATA,
        ST_HOLD,
        ST_SKIP
    } rx_state_e;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_rx_busmon.sv
module i2c_rx_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Data line edges count as conditions only while the clock stays high.
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              buf_full,
    input  logic              rd_en,
    input  logic              rel_set,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              ev_load,
    output logic [DATA_W-1:0] ev_byte,
    output logic              ev_ovf,
    output logic              ev_irq,
    output logic              ev_hold
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              byte_done;
    logic              addr_hit;
    logic              full_eff;
    logic              shifting;

    assign byte_done = scl_fall && (cnt_q == CNT_W'(DATA_W));
    assign addr_hit  = (shreg_q[DATA_W-1 -: ADDR_W] == own_addr) && !shreg_q[0];
    // A read in the same cycle frees the register for the decision.
    assign full_eff  = buf_full & ~rd_en;
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign ev_byte   = shreg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transition logic and event pulses
    always_comb begin
        state_d = state_q;
        ev_load = 1'b0;
        ev_ovf  = 1'b0;
        ev_irq  = 1'b0;
        ev_hold = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR: begin
                    if (byte_done) begin
                        if (!addr_hit) begin
                            state_d = ST_SKIP;
                        end else if (full_eff) begin
                            ev_ovf  = 1'b1;
                            state_d = ST_SKIP;
                        end else begin
                            ev_load = 1'b1;
                            state_d = ST_ACK;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        if (full_eff) begin
                            ev_ovf  = 1'b1;
                            state_d = ST_NACK;
                        end else begin
                            ev_load = 1'b1;
                            state_d = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ev_irq = 1'b1;
                        if (stretch_en && full_eff) begin
                            ev_hold = 1'b1;
                            state_d = ST_HOLD;
                        end else begin
                            state_d = ST_DATA;
                        end
                    end
                end
                ST_NACK: begin
                    if (scl_fall) state_d = ST_DATA;
                end
                ST_HOLD: begin
                    if (rel_set) state_d = ST_DATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Pad outputs, decoded from the registered state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_ACK:  sda_oe = 1'b1;
            ST_HOLD: scl_oe = 1'b1;
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    // Bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (start_det || stop_det || (state_d != state_q)) begin
            cnt_q <= '0;
        end else if (scl_rise && shifting && (cnt_q < CNT_W'(DATA_W))) begin
            shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_load,
    input  logic [DATA_W-1:0] ev_byte,
    input  logic              ev_ovf,
    input  logic              ev_irq,
    input  logic              ev_hold,
    input  logic              rd_en,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    input  logic              rel_set,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              clk_rel
);

    // Hardware set events take priority over host clear strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
            clk_rel  <= 1'b1;
        end else begin
            if (ev_load) begin
                rd_data  <= ev_byte;
                buf_full <= 1'b1;
            end else if (rd_en) begin
                buf_full <= 1'b0;
            end
            if (ev_ovf)       ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
            if (ev_irq)       irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;
            if (ev_hold)      clk_rel <= 1'b0;
            else if (rel_set) clk_rel <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    input  logic              rel_set,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              clk_rel
);

    logic [1:0]        pads_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ev_load;
    logic              ev_ovf;
    logic              ev_irq;
    logic              ev_hold;
    logic [DATA_W-1:0] ev_byte;

    i2c_rx_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pads_s)
    );

    i2c_rx_busmon u_busmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (pads_s[1]),
        .sda_s    (pads_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rx_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (pads_s[0]),
        .own_addr  (own_addr),
        .stretch_en(stretch_en),
        .buf_full  (buf_full),
        .rd_en     (rd_en),
        .rel_set   (rel_set),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .ev_load   (ev_load),
        .ev_byte   (ev_byte),
        .ev_ovf    (ev_ovf),
        .ev_irq    (ev_irq),
        .ev_hold   (ev_hold)
    );

    i2c_rx_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_load (ev_load),
        .ev_byte (ev_byte),
        .ev_ovf  (ev_ovf),
        .ev_irq  (ev_irq),
        .ev_hold (ev_hold),
        .rd_en   (rd_en),
        .clr_irq (clr_irq),
        .clr_ovf (clr_ovf),
        .rel_set (rel_set),
        .rd_data (rd_data),
        .buf_full(buf_full),
        .ovf     (ovf),
        .irq     (irq),
        .clk_rel (clk_rel)
    );

endmodule

// File: rtl/i2c_wr_slave_chk.sv
module i2c_wr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic stretch_en,
    input logic rel_set,
    input logic clr_ovf,
    input logic scl_oe,
    input logic sda_oe,
    input logic buf_full,
    input logic ovf,
    input logic clk_rel
);

    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_hold_until_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !rel_set) |=> scl_oe);

    p_rel_bit_low_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !clk_rel);

    p_no_ack_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);

    p_stretch_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(stretch_en));

    p_stretch_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(buf_full));

    p_ovf_without_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> !sda_oe);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

endmodule

bind i2c_wr_slave i2c_wr_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .stretch_en(stretch_en),
    .rel_set   (rel_set),
    .clr_ovf   (clr_ovf),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .buf_full  (buf_full),
    .ovf       (ovf),
    .clk_rel   (clk_rel)
);

// File: tb/i2c_wr_slave_tb.sv
module i2c_wr_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_oe, sda_oe;
    logic [6:0] own_addr = 7'h5A;
    logic       stretch_en = 1'b0;
    logic       rd_en = 1'b0, clr_irq = 1'b0, clr_ovf = 1'b0, rel_set = 1'b0;
    logic [7:0] rd_data;
    logic       buf_full, ovf, irq, clk_rel;
    logic       scl_bus, sda_bus;
    int         checks = 0;
    int         errors = 0;
    int         sda_bad = 0;
    logic       sda_oe_prev = 1'b0;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wr_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .own_addr  (own_addr),
        .stretch_en(stretch_en),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .clr_irq   (clr_irq),
        .clr_ovf   (clr_ovf),
        .rel_set   (rel_set),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq),
        .clk_rel   (clk_rel)
    );

    // R11 monitor: acknowledge drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== sda_oe_prev) && scl_bus) sda_bad++;
        sda_oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high;
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rd_en = 1'b1;
            1: clr_irq = 1'b1;
            2: clr_ovf = 1'b1;
            default: rel_set = 1'b1;
        endcase
        @(negedge clk);
        rd_en = 1'b0; clr_irq = 1'b0; clr_ovf = 1'b0; rel_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic m_start;
        m_sda = 1'b1; wait_q;
        m_scl = 1'b1; wait_scl_high; wait_q;
        m_sda = 1'b0; wait_q;
        m_scl = 1'b0; wait_q;
    endtask

    task automatic m_stop;
        m_sda = 1'b0; wait_q;
        m_scl = 1'b1; wait_scl_high; wait_q;
        m_sda = 1'b1; wait_q;
    endtask

    task automatic m_bit(input logic b);
        m_sda = b; wait_q;
        m_scl = 1'b1; wait_scl_high; wait_q;
        m_scl = 1'b0; wait_q;
    endtask

    task automatic m_byte(input logic [7:0] b, input bit rd_mid, output bit acked);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_sda = 1'b1; wait_q;
        m_scl = 1'b1; wait_scl_high; wait_q;
        acked = !sda_bus;
        if (rd_mid) begin
            @(negedge clk) rd_en = 1'b1;
            @(negedge clk) rd_en = 1'b0;
        end
        wait_q;
        m_scl = 1'b0; wait_q;
    endtask

    task automatic t_reset;
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "buf_full", buf_full, 0);
        chk("R1", "ovf", ovf, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "clk_rel", clk_rel, 1);
    endtask

    task automatic t_stretch;
        bit ack;
        stretch_en = 1'b1;
        m_start;
        m_byte({7'h5A, 1'b0}, 0, ack);
        chk("R2", "address ack", ack, 1);
        chk("R3", "address byte", rd_data, 8'hB4);
        chk("R3", "buf_full", buf_full, 1);
        chk("R3", "irq", irq, 1);
        chk("R5", "scl held", scl_oe, 1);
        chk("R5", "clk_rel cleared", clk_rel, 0);
        pulse(0);
        chk("R4", "read clears full", buf_full, 0);
        chk("R5", "read keeps hold", scl_oe, 1);
        pulse(1);
        chk("R4", "irq cleared", irq, 0);
        pulse(3);
        chk("R5", "released", scl_oe, 0);
        chk("R5", "clk_rel set", clk_rel, 1);
        m_byte(8'hC3, 1, ack);
        chk("R6", "early read ack", ack, 1);
        chk("R3", "data byte", rd_data, 8'hC3);
        chk("R6", "no stretch", scl_oe, 0);
        chk("R6", "clk_rel kept", clk_rel, 1);
        chk("R4", "full cleared by read", buf_full, 0);
        pulse(1);
        m_byte(8'h69, 0, ack);
        chk("R5", "second data ack", ack, 1);
        chk("R5", "second stretch", scl_oe, 1);
        chk("R3", "second byte", rd_data, 8'h69);
        pulse(0);
        pulse(1);
        pulse(3);
        m_stop;
        m_scl = 1'b0; wait_q;
        m_byte(8'hA5, 0, ack);
        chk("R10", "no ack after stop", ack, 0);
        chk("R10", "no load after stop", buf_full, 0);
        chk("R10", "buffer kept", rd_data, 8'h69);
        chk("R10", "no irq after stop", irq, 0);
        m_scl = 1'b1; wait_q;
    endtask

    task automatic t_overflow;
        bit ack;
        stretch_en = 1'b0;
        m_start;
        m_byte({7'h5A, 1'b0}, 0, ack);
        chk("R7", "address ack", ack, 1);
        chk("R7", "no stretch", scl_oe, 0);
        chk("R7", "clk_rel kept", clk_rel, 1);
        m_byte(8'h11, 0, ack);
        chk("R8", "refused byte nack", ack, 0);
        chk("R8", "ovf set", ovf, 1);
        chk("R8", "buffer kept", rd_data, 8'hB4);
        chk("R8", "no stretch", scl_oe, 0);
        pulse(0);
        chk("R9", "ovf after read", ovf, 1);
        m_byte(8'h22, 0, ack);
        chk("R9", "accepted after read", ack, 1);
        chk("R9", "new byte", rd_data, 8'h22);
        chk("R9", "ovf still set", ovf, 1);
        pulse(2);
        chk("R4", "ovf cleared", ovf, 0);
        pulse(0);
        pulse(1);
        m_stop;
    endtask

    task automatic t_mismatch;
        bit ack;
        stretch_en = 1'b1;
        m_start;
        m_byte({7'h33, 1'b0}, 0, ack);
        chk("R2", "wrong address nack", ack, 0);
        chk("R2", "no load", buf_full, 0);
        chk("R2", "no irq", irq, 0);
        chk("R2", "no stretch", scl_oe, 0);
        m_byte(8'h5A, 0, ack);
        chk("R2", "ignored data nack", ack, 0);
        chk("R2", "ignored data no load", buf_full, 0);
        m_start;
        m_byte({7'h5A, 1'b1}, 0, ack);
        chk("R2", "read direction nack", ack, 0);
        chk("R2", "read direction no load", buf_full, 0);
        m_start;
        m_byte({7'h5A, 1'b0}, 0, ack);
        chk("R10", "repeated start ack", ack, 1);
        chk("R10", "repeated start load", buf_full, 1);
        chk("R10", "repeated start stretch", scl_oe, 1);
        pulse(0);
        pulse(1);
        pulse(3);
        m_stop;
        chk("R11", "sda moved with SCL high", sda_bad, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_stretch;
        t_overflow;
        t_mismatch;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule